// File: doc/BRIEF.md
# Dual-Clock Frequency Cross-Checker

This block checks that the system clock runs at the expected rate. It compares the clock against a slow reference tick that comes from an independent oscillator. A 16-bit cycle counter and a 16-bit wrap counter together measure how many system cycles pass between two reference ticks. When a tick arrives, the 32-bit total is compared with a programmed expected count. The allowed deviation is a percentage of that expected count.

The check also works the other way round. If the reference stops or slows down, the wrap counter keeps growing. Once it passes a programmed limit, the block reports a missing reference. A too-fast clock, a too-slow clock and a missing reference each have their own cause code. The first fault latches until software-side logic clears it. Each time the block is enabled it starts from a partial interval, so the first tick after reset or enable only starts a measurement and is not judged.

Top module: `freq_xcheck`

## Requirements
- R1: The measured count is the number of system clock cycles between two consecutive accepted reference ticks. Its upper 16 bits come from a wrap counter that advances each time the lower 16-bit cycle counter rolls over, so intervals longer than 65535 cycles are measured exactly.
- R2: A measurement that differs from `exp_count` by at most floor(`exp_count` * `tol_pct` / 100) raises no error.
- R3: A measurement below `exp_count` by more than the tolerance latches cause code 2'b01 (system clock slow).
- R4: A measurement above `exp_count` by more than the tolerance latches cause code 2'b10 (system clock fast).
- R5: When the wrap counter exceeds `ovf_limit` before the next tick, cause code 2'b11 (reference missing) latches. It takes priority over a frequency result in the same cycle.
- R6: The first tick after reset, or after `enable` rises, only starts a measurement and is never judged.
- R7: Once an error has latched, `err_flag` stays high and `err_cause` keeps the first cause, even when later ticks or wraps would report a different fault.
- R8: `err_clear` high at a clock edge returns `err_flag` to 0 and `err_cause` to 2'b00. Clear wins over a new fault detected at the same edge.
- R9: While `enable` is low, both counters are held at zero and no error can latch.
- R10: After reset, `err_flag` is 0 and `err_cause` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock under test |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the checker; low holds counters and suppresses errors |
| ref_tick_async | input | 1 | Reference tick from the independent clock, asynchronous level |
| exp_count | input | 32 | Expected system cycles per reference interval |
| tol_pct | input | 7 | Allowed deviation as a percentage of exp_count |
| ovf_limit | input | 16 | Largest wrap count accepted before a tick must arrive |
| err_clear | input | 1 | Clears the latched error |
| err_flag | output | 1 | Sticky error indication |
| err_cause | output | 2 | 00 none, 01 slow, 10 fast, 11 reference missing |

## Verification
Take a tick whose rising level is set up before clock edge N. It passes through two synchroniser flops and an edge register, so the comparison is made at edge N+2. The latched cause becomes visible just after that edge. A missing reference latches one edge after the wrap counter passes the limit, and a clear acts at the next edge. The bench drives ticks on falling edges, spaced exactly the intended number of cycles apart. It samples outputs on a falling edge at least five cycles after the last tick, so every result has already settled. Before checking the missing-reference case, it samples once below the wrap point and once above it.

// File: rtl/fxc_pkg.sv
// Shared types for the frequency cross-checker.
// Assumes: cause codes are decoded by logic outside the block, so values are fixed.
package fxc_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_SLOW  = 2'b01,
        CAUSE_FAST  = 2'b10,
        CAUSE_NOREF = 2'b11
    } cause_e;
endpackage

// File: rtl/fxc_tick_sync.sv
// Brings the asynchronous reference tick into the system domain and emits a
// one-cycle pulse per rising level.
// Assumes: the tick stays high for at least two system cycles.
module fxc_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_async,
    output logic tick_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the raw level through the synchroniser chain and keep the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], tick_async};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Rising edge of the synchronised level.
    assign tick_pulse = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/fxc_span_counter.sv
// Counts system cycles in one reference interval: a low cycle counter plus a
// saturating wrap counter that forms the upper part of the measurement.
// Assumes: restart coincides with the tick that ends an interval; the tick
// cycle itself is the first cycle of the new interval.
module fxc_span_counter #(
    parameter int LO_W = 16,
    parameter int HI_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    output logic [LO_W-1:0] lo_cnt,
    output logic [HI_W-1:0] hi_cnt
);
    localparam logic [LO_W-1:0] LO_ONE = LO_W'(1);
    localparam logic [HI_W-1:0] HI_ONE = HI_W'(1);

    logic lo_wrap;
    assign lo_wrap = (lo_cnt == '1);

    // Low cycle counter: hold at zero when idle, restart at one on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            lo_cnt <= '0;
        end else if (restart) begin
            lo_cnt <= LO_ONE;
        end else begin
            lo_cnt <= lo_cnt + LO_ONE;
        end
    end

    // Wrap counter: advance on each low rollover, saturate at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hi_cnt <= '0;
        end else if (restart) begin
            hi_cnt <= '0;
        end else if (lo_wrap && (hi_cnt != '1)) begin
            hi_cnt <= hi_cnt + HI_ONE;
        end
    end
endmodule

// File: rtl/fxc_band_cmp.sv
// Derives the absolute tolerance from a percentage and classifies a
// measurement as slow, fast or in band.
// Assumes: exp_count and tol_pct are quasi-static; the tolerance is
// registered and follows a change one cycle later.
module fxc_band_cmp #(
    parameter int MEAS_W = 32,
    parameter int PCT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MEAS_W-1:0] exp_count,
    input  logic [PCT_W-1:0]  tol_pct,
    input  logic [MEAS_W-1:0] meas,
    output logic              is_slow,
    output logic              is_fast
);
    localparam int PROD_W = MEAS_W + PCT_W;
    localparam logic [PROD_W-1:0] HUNDRED = PROD_W'(100);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;
    logic [MEAS_W-1:0] tol_q;
    logic [MEAS_W-1:0] below_by;
    logic [MEAS_W-1:0] above_by;

    // Scale the expected count by the percentage.
    always_comb begin
        prod = {{PCT_W{1'b0}}, exp_count} * {{MEAS_W{1'b0}}, tol_pct};
        quot = prod / HUNDRED;
    end

    // Register the tolerance to keep the divider off the compare path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tol_q <= '0;
        end else begin
            tol_q <= quot[MEAS_W-1:0];
        end
    end

    // Distance of the measurement from the expectation in each direction.
    always_comb begin
        below_by = exp_count - meas;
        above_by = meas - exp_count;
        is_slow  = (meas < exp_count) && (below_by > tol_q);
        is_fast  = (meas > exp_count) && (above_by > tol_q);
    end
endmodule

// File: rtl/freq_xcheck.sv
// Top of the frequency cross-checker: synchronises the reference tick,
// measures system cycles per interval, judges each interval against the
// expected count and watches for a reference that stops.
// Assumes: rst_n is synchronous to clk; configuration changes only while
// enable is low or errors are ignored.
module freq_xcheck
    import fxc_pkg::*;
#(
    parameter int LO_W        = 16,
    parameter int HI_W        = 16,
    parameter int PCT_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 ref_tick_async,
    input  logic [LO_W+HI_W-1:0] exp_count,
    input  logic [PCT_W-1:0]     tol_pct,
    input  logic [HI_W-1:0]      ovf_limit,
    input  logic                 err_clear,
    output logic                 err_flag,
    output logic [1:0]           err_cause
);
    localparam int MEAS_W = LO_W + HI_W;

    logic              tick_pulse;
    logic [LO_W-1:0]   lo_cnt;
    logic [HI_W-1:0]   ovf_cnt;
    logic [MEAS_W-1:0] meas;
    logic              is_slow;
    logic              is_fast;
    logic              armed_q;
    logic              freq_hit;
    logic              miss_hit;
    cause_e            cause_q;
    cause_e            new_cause;

    fxc_tick_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_async(ref_tick_async),
        .tick_pulse(tick_pulse)
    );

    fxc_span_counter #(
        .LO_W(LO_W),
        .HI_W(HI_W)
    ) u_span (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (enable),
        .restart(tick_pulse),
        .lo_cnt (lo_cnt),
        .hi_cnt (ovf_cnt)
    );

    assign meas = {ovf_cnt, lo_cnt};

    fxc_band_cmp #(
        .MEAS_W(MEAS_W),
        .PCT_W (PCT_W)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .exp_count(exp_count),
        .tol_pct  (tol_pct),
        .meas     (meas),
        .is_slow  (is_slow),
        .is_fast  (is_fast)
    );

    // Arm after the first tick of a run so the partial interval is skipped.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            armed_q <= 1'b0;
        end else if (tick_pulse) begin
            armed_q <= 1'b1;
        end
    end

    // Fault detection for this cycle, with missing reference ranked first.
    always_comb begin
        freq_hit  = enable && tick_pulse && armed_q && (is_slow || is_fast);
        miss_hit  = enable && (ovf_cnt > ovf_limit);
        new_cause = CAUSE_NONE;
        if (miss_hit) begin
            new_cause = CAUSE_NOREF;
        end else if (freq_hit) begin
            new_cause = is_slow ? CAUSE_SLOW : CAUSE_FAST;
        end
    end

    // Sticky cause register: first fault holds until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || err_clear) begin
            cause_q <= CAUSE_NONE;
        end else if (cause_q == CAUSE_NONE) begin
            cause_q <= new_cause;
        end
    end

    assign err_cause = cause_q;
    assign err_flag  = (cause_q != CAUSE_NONE);
endmodule

// File: rtl/fxc_checker.sv
// Property checker for freq_xcheck, attached by bind.
// Assumes: sees top ports plus the wrap counter and the tick pulse.
module fxc_checker #(
    parameter int HI_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic            err_clear,
    input logic [HI_W-1:0] ovf_limit,
    input logic            err_flag,
    input logic [1:0]      err_cause,
    input logic [HI_W-1:0] ovf_cnt,
    input logic            tick_pulse
);
    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clear) |=> (err_flag && $stable(err_cause)));

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_clear |=> (!err_flag && err_cause == 2'b00));

    // R5
    noref_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !err_flag && !err_clear && (ovf_cnt > ovf_limit))
        |=> (err_cause == 2'b11));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !err_flag && !err_clear) |=> !err_flag);

    // R9
    idle_counter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (ovf_cnt == '0));

    // R3 R4: a frequency cause only appears right after a tick
    freq_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err_flag) && err_cause != 2'b11) |-> $past(tick_pulse));
endmodule

bind freq_xcheck fxc_checker #(.HI_W(HI_W)) u_fxc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .err_clear (err_clear),
    .ovf_limit (ovf_limit),
    .err_flag  (err_flag),
    .err_cause (err_cause),
    .ovf_cnt   (ovf_cnt),
    .tick_pulse(tick_pulse)
);

// File: tb/test_freq_xcheck.sv
module test_freq_xcheck;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 195000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        ref_tick_async;
    logic [31:0] exp_count;
    logic [6:0]  tol_pct;
    logic [15:0] ovf_limit;
    logic        err_clear;
    logic        err_flag;
    logic [1:0]  err_cause;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    freq_xcheck i_freq_xcheck (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .ref_tick_async(ref_tick_async),
        .exp_count     (exp_count),
        .tol_pct       (tol_pct),
        .ovf_limit     (ovf_limit),
        .err_clear     (err_clear),
        .err_flag      (err_flag),
        .err_cause     (err_cause)
    );

    task automatic check(input string req, input logic [1:0] want);
        total++;
        if (err_cause !== want || err_flag !== (want != 2'b00)) begin
            bad++;
            $display("FAIL %s: flag=%0b cause=%02b expected flag=%0b cause=%02b",
                     req, err_flag, err_cause, (want != 2'b00), want);
        end
    endtask

    // Rising tick now, next rising tick exactly gap cycles later.
    task automatic pulse_gap(input int gap);
        ref_tick_async = 1'b1;
        repeat (3) @(negedge clk);
        ref_tick_async = 1'b0;
        repeat (gap - 3) @(negedge clk);
    endtask

    task automatic restart(input logic [31:0] e, input logic [6:0] p, input logic [15:0] lim);
        enable = 1'b0; err_clear = 1'b1; ref_tick_async = 1'b0;
        exp_count = e; tol_pct = p; ovf_limit = lim;
        repeat (3) @(negedge clk);
        err_clear = 1'b0; enable = 1'b1;
        @(negedge clk);
    endtask

    // One measured interval of length gap, judged with a short closing gap.
    task automatic measure(input int gap, input string req, input logic [1:0] want);
        pulse_gap(gap);
        pulse_gap(8);
        check(req, want);
    endtask

    task automatic t_reset;
        check("R10 reset state", 2'b00);
    endtask

    task automatic t_in_band;
        restart(1000, 10, 16'd4);
        measure(1000, "R1 R2 exact count", 2'b00);
        restart(1000, 10, 16'd4);
        measure(1100, "R2 upper edge", 2'b00);
        restart(1000, 10, 16'd4);
        measure(900, "R2 lower edge", 2'b00);
    endtask

    task automatic t_fast;
        restart(1000, 10, 16'd4);
        measure(1101, "R4 just above band", 2'b10);
    endtask

    task automatic t_slow;
        restart(1000, 10, 16'd4);
        measure(899, "R3 just below band", 2'b01);
    endtask

    task automatic t_first_skip;
        restart(1000, 10, 16'd4);
        repeat (50) @(negedge clk);
        pulse_gap(8);
        check("R6 first tick not judged", 2'b00);
    endtask

    task automatic t_sticky_clear;
        restart(1000, 10, 16'd4);
        measure(1200, "R4 fast", 2'b10);
        pulse_gap(8);
        check("R7 later slow ignored", 2'b10);
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        check("R8 clear", 2'b00);
    endtask

    task automatic t_disabled;
        restart(1000, 10, 16'd4);
        enable = 1'b0;
        pulse_gap(20);
        pulse_gap(20);
        pulse_gap(20);
        check("R9 no error while disabled", 2'b00);
        enable = 1'b1;
    endtask

    task automatic t_zero_tol;
        restart(500, 0, 16'd4);
        measure(500, "R2 zero tolerance exact", 2'b00);
        restart(500, 0, 16'd4);
        measure(501, "R4 zero tolerance one over", 2'b10);
    endtask

    task automatic t_wide;
        restart(66000, 0, 16'd1);
        measure(66000, "R1 count above 16 bits", 2'b00);
    endtask

    task automatic t_missing;
        restart(1000, 10, 16'd0);
        repeat (65000) @(negedge clk);
        check("R5 before wrap", 2'b00);
        repeat (600) @(negedge clk);
        check("R5 reference missing", 2'b11);
    endtask

    initial begin
        rst_n = 1'b0; enable = 1'b0; ref_tick_async = 1'b0; err_clear = 1'b0;
        exp_count = 32'd1000; tol_pct = 7'd10; ovf_limit = 16'd4;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_in_band();
        t_fast();
        t_slow();
        t_first_skip();
        t_sticky_clear();
        t_disabled();
        t_zero_tol();
        t_wide();
        t_missing();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule